// File: doc/BRIEF.md
# Pot Coincidence Halo Classifier

This block grades hits from a forward proton detector array, once per bunch crossing. Each crossing delivers two 22-bit hit vectors. One holds the in-time hits and the other holds the early hits. Early hits are the ones that arrive ahead of the interaction time of flight and so point to beam halo. From these vectors the block forms a 4-bit status code for each of nine spectrometers.

Eight of the spectrometers are quadrupole spectrometers, one for each of four directions (Up, Down, In, Out) on each of two arms. Each has a first-station pot and a second-station pot. The ninth spectrometer is built from the two dipole pots. A quadrupole spectrometer reports a coincidence when both of its pots have an in-time hit. It then grades that coincidence by the halo bits of its diagonally opposite partner: the spectrometer on the other arm with the direction reversed (Up with Down, In with Out). A downstream trigger decision uses code 1 as a clean track candidate and codes 2 and 3 as halo-contaminated.

The codes are captured on a bunch-crossing strobe. A one-cycle valid pulse marks each new set of codes, and the codes then hold until the next strobe.

Top module: `pot_coinc_classifier`

## Requirements
- R1: Hit bit layout, identical for `hit_intime` and `hit_halo`. Quadrupole pot bit = arm*8 + dir*2 + station, with dir Up=0, Down=1, In=2, Out=3 and station 0 = first station, 1 = second station. Bits 16 and 17 are the first and second dipole pots. Bits 18 to 21 are veto counters. Quadrupole spectrometer s = arm*4 + dir; the dipole spectrometer is s = 8. The code of spectrometer s is `spec_code[4s+3:4s]`.
- R2: A spectrometer whose two pots do not both have an in-time bit set reports code 0, whatever the halo bits are.
- R3: A quadrupole spectrometer with an in-time coincidence reports code 1 when neither pot of its opposite spectrometer has a halo bit set.
- R4: With a coincidence and exactly one opposite pot's halo bit set, the code is 2.
- R5: With a coincidence and both opposite pots' halo bits set, the code is 3.
- R6: The opposite of spectrometer s is found by swapping the arm and exchanging Up with Down and In with Out. The spectrometer's own halo bits, and the halo bits of any spectrometer other than its opposite, have no effect on its code.
- R7: The dipole spectrometer reports 1 when both dipole pots have an in-time hit and 0 otherwise. Halo bits never affect it.
- R8: The veto counter bits (18 to 21), in-time and halo, have no effect on any code.
- R9: Bits 3 and 2 of every code are always 0.
- R10: When `bx_strobe` is high at a rising clock edge, the codes for the inputs sampled at that edge appear after that edge, and `codes_valid` is high for exactly the following cycle. While the strobe is low, the codes hold and the inputs are not sampled. Back-to-back strobes give one new set of codes per cycle.
- R11: Synchronous active-high `rst` clears every code to 0 and deasserts `codes_valid`, and it takes priority over the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_strobe | input | 1 | Bunch-crossing capture strobe |
| hit_intime | input | 22 | In-time hit bits (layout in R1) |
| hit_halo | input | 22 | Early (halo) hit bits (layout in R1) |
| spec_code | output | 36 | Nine 4-bit spectrometer codes; spectrometer s occupies bits 4s+3 to 4s |
| codes_valid | output | 1 | High for the one cycle after each strobe |

## Verification
Some checks run on every cycle. The assertions confirm that valid follows the strobe by one cycle and that codes stay unchanged between strobes. They also confirm that a missing coincidence always yields 0, that a coincidence yields 1 or 3 when the opposite spectrometer's halo bits are both clear or both set, and that the dipole code never exceeds 1. Other behaviour can only be shown by the bench's scenarios, where chosen halo patterns are compared against an independent model of the arm and direction pairing: that a spectrometer ignores its own halo bits and every non-opposite halo bit, that the veto bits change nothing, and that reset beats a strobe.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int N_ARMS   = 2;
    localparam int N_DIRS   = 4;
    localparam int N_STN    = 2;
    localparam int N_QSPEC  = N_ARMS * N_DIRS;
    localparam int N_SPEC   = N_QSPEC + 1;
    localparam int N_QPOT   = N_QSPEC * N_STN;
    localparam int N_DIPOLE = 2;
    localparam int N_VETO   = 4;
    localparam int N_HIT    = N_QPOT + N_DIPOLE + N_VETO;
    localparam int DIP_BASE = N_QPOT;
    localparam int CODE_W   = 4;
    localparam int GRADE_W  = 2;
    localparam int CODES_W  = N_SPEC * CODE_W;

    typedef enum logic [GRADE_W-1:0] {
        GRADE_NONE     = 2'd0,
        GRADE_CLEAN    = 2'd1,
        GRADE_ONE_HALO = 2'd2,
        GRADE_TWO_HALO = 2'd3
    } grade_e;

    typedef struct packed {
        logic second;
        logic first;
    } pot_pair_t;

    // Opposite spectrometer: other arm, direction reversed (Up<->Down, In<->Out).
    function automatic int unsigned opp_spec(input int unsigned s);
        int unsigned arm;
        int unsigned dir;
        arm = s / N_DIRS;
        dir = s % N_DIRS;
        return (N_ARMS - 1 - arm) * N_DIRS + (dir ^ 1);
    endfunction

    function automatic grade_e grade_of(input pot_pair_t own_it, input pot_pair_t opp_halo);
        if (!(own_it.first && own_it.second))
            return GRADE_NONE;
        case ({opp_halo.second, opp_halo.first})
            2'b00:   return GRADE_CLEAN;
            2'b11:   return GRADE_TWO_HALO;
            default: return GRADE_ONE_HALO;
        endcase
    endfunction

endpackage

// File: rtl/pcc_hit_router.sv
module pcc_hit_router
    import pcc_pkg::*;
(
    input  logic [N_HIT-1:0]  intime,
    input  logic [N_HIT-1:0]  halo,
    output pot_pair_t [N_SPEC-1:0] own_it,
    output pot_pair_t [N_SPEC-1:0] opp_halo
);

    genvar s;
    generate
        for (s = 0; s < N_QSPEC; s++) begin : g_quad
            localparam int unsigned OPP = opp_spec(s);
            assign own_it[s]   = intime[s*N_STN +: N_STN];
            assign opp_halo[s] = halo[OPP*N_STN +: N_STN];
        end
    endgenerate

    // Dipole spectrometer has no partner: its halo input is tied clear.
    assign own_it[N_QSPEC]   = intime[DIP_BASE +: N_DIPOLE];
    assign opp_halo[N_QSPEC] = '0;

    logic unused_hits;
    assign unused_hits = ^{intime[N_HIT-1:DIP_BASE+N_DIPOLE], halo[N_HIT-1:DIP_BASE]};

endmodule

// File: rtl/pcc_spec_grader.sv
module pcc_spec_grader
    import pcc_pkg::*;
(
    input  pot_pair_t own_it,
    input  pot_pair_t opp_halo,
    output grade_e    grade
);

    assign grade = grade_of(own_it, opp_halo);

endmodule

// File: rtl/pcc_out_reg.sv
module pcc_out_reg
    import pcc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture,
    input  grade_e [N_SPEC-1:0]  grade_in,
    output logic [CODES_W-1:0]   codes,
    output logic                 valid
);

    logic [CODES_W-1:0] codes_next;

    always_comb begin
        for (int s = 0; s < N_SPEC; s++)
            codes_next[s*CODE_W +: CODE_W] = {{(CODE_W-GRADE_W){1'b0}}, grade_in[s]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            codes <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture)
                codes <= codes_next;
        end
    end

endmodule

// File: rtl/pot_coinc_classifier.sv
module pot_coinc_classifier
    import pcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bx_strobe,
    input  logic [N_HIT-1:0]   hit_intime,
    input  logic [N_HIT-1:0]   hit_halo,
    output logic [CODES_W-1:0] spec_code,
    output logic               codes_valid
);

    pot_pair_t [N_SPEC-1:0] own_it;
    pot_pair_t [N_SPEC-1:0] opp_halo;
    grade_e    [N_SPEC-1:0] grades;

    pcc_hit_router u_router (
        .intime   (hit_intime),
        .halo     (hit_halo),
        .own_it   (own_it),
        .opp_halo (opp_halo)
    );

    genvar s;
    generate
        for (s = 0; s < N_SPEC; s++) begin : g_grade
            pcc_spec_grader u_grader (
                .own_it   (own_it[s]),
                .opp_halo (opp_halo[s]),
                .grade    (grades[s])
            );
        end
    endgenerate

    pcc_out_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .capture  (bx_strobe),
        .grade_in (grades),
        .codes    (spec_code),
        .valid    (codes_valid)
    );

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
    import pcc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bx_strobe,
    input logic [N_HIT-1:0]   hit_intime,
    input logic [N_HIT-1:0]   hit_halo,
    input logic [CODES_W-1:0] spec_code,
    input logic               codes_valid
);

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        bx_strobe |=> codes_valid);

    p_valid_drops_r10: assert property (@(posedge clk) disable iff (rst)
        !bx_strobe |=> !codes_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !bx_strobe |=> $stable(spec_code));

    p_dipole_max_one_r7: assert property (@(posedge clk) disable iff (rst)
        spec_code[N_QSPEC*CODE_W +: CODE_W] <= 4'd1);

    p_dipole_nocoinc_r2: assert property (@(posedge clk) disable iff (rst)
        (bx_strobe && !(hit_intime[DIP_BASE] && hit_intime[DIP_BASE+1]))
        |=> spec_code[N_QSPEC*CODE_W +: CODE_W] == 4'd0);

    genvar s;
    generate
        for (s = 0; s < N_QSPEC; s++) begin : g_spec
            // opposite index: flip arm bit and low direction bit
            localparam int P0 = 2 * s;
            localparam int Q0 = 2 * (s ^ 5);

            p_nocoinc_zero_r2: assert property (@(posedge clk) disable iff (rst)
                (bx_strobe && !(hit_intime[P0] && hit_intime[P0+1]))
                |=> spec_code[s*CODE_W +: CODE_W] == 4'd0);

            p_clean_one_r3: assert property (@(posedge clk) disable iff (rst)
                (bx_strobe && hit_intime[P0] && hit_intime[P0+1]
                 && !hit_halo[Q0] && !hit_halo[Q0+1])
                |=> spec_code[s*CODE_W +: CODE_W] == 4'd1);

            p_both_halo_r5: assert property (@(posedge clk) disable iff (rst)
                (bx_strobe && hit_intime[P0] && hit_intime[P0+1]
                 && hit_halo[Q0] && hit_halo[Q0+1])
                |=> spec_code[s*CODE_W +: CODE_W] == 4'd3);
        end
    endgenerate

endmodule

bind pot_coinc_classifier pcc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bx_strobe   (bx_strobe),
    .hit_intime  (hit_intime),
    .hit_halo    (hit_halo),
    .spec_code   (spec_code),
    .codes_valid (codes_valid)
);

// File: tb/sim_pot_coinc_classifier.sv
`timescale 1ns/1ps
module sim_pot_coinc_classifier;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bx_strobe = 1'b0;
    logic [21:0] hit_intime = '0;
    logic [21:0] hit_halo = '0;
    logic [35:0] spec_code;
    logic        codes_valid;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #5 clk = ~clk;

    pot_coinc_classifier u0 (
        .clk         (clk),
        .rst         (rst),
        .bx_strobe   (bx_strobe),
        .hit_intime  (hit_intime),
        .hit_halo    (hit_halo),
        .spec_code   (spec_code),
        .codes_valid (codes_valid)
    );

    // Reference from requirement R1..R9.
    function automatic logic [35:0] model(input logic [21:0] it, input logic [21:0] hl);
        logic [35:0] r;
        r = '0;
        for (int arm = 0; arm < 2; arm++) begin
            for (int dir = 0; dir < 4; dir++) begin
                int oarm, odir, nh;
                logic [3:0] c;
                oarm = 1 - arm;
                case (dir)
                    0: odir = 1;
                    1: odir = 0;
                    2: odir = 3;
                    default: odir = 2;
                endcase
                nh = int'(hl[oarm*8 + odir*2]) + int'(hl[oarm*8 + odir*2 + 1]);
                if (it[arm*8 + dir*2] && it[arm*8 + dir*2 + 1]) c = 4'(1 + nh);
                else c = 4'd0;
                r[(arm*4 + dir)*4 +: 4] = c;
            end
        end
        r[35:32] = (it[16] && it[17]) ? 4'd1 : 4'd0;
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        logic [31:0] x;
        x = v;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Strobe one vector, check the valid cycle and a hold cycle with scrambled inputs.
    task automatic apply(input string req, input logic [21:0] it, input logic [21:0] hl);
        logic [35:0] e;
        e = model(it, hl);
        @(negedge clk);
        hit_intime = it;
        hit_halo = hl;
        bx_strobe = 1'b1;
        @(negedge clk);
        bx_strobe = 1'b0;
        chk({req, " valid"}, 64'(codes_valid), 64'd1);
        chk({req, " code"}, 64'(spec_code), 64'(e));
        lfsr = nxt(lfsr);
        hit_intime = lfsr[21:0];
        hit_halo = ~lfsr[31:10];
        @(negedge clk);
        chk({req, " R10 valid drop"}, 64'(codes_valid), 64'd0);
        chk({req, " R10 hold"}, 64'(spec_code), 64'(e));
    endtask

    task automatic t_reset;
        @(negedge clk);
        hit_intime = '1;
        hit_halo = '0;
        bx_strobe = 1'b1;
        @(negedge clk);
        chk("R11 reset codes", 64'(spec_code), 64'd0);
        chk("R11 reset valid", 64'(codes_valid), 64'd0);
        bx_strobe = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_no_coinc;
        apply("R2 first stations only", 22'h05555, 22'h3FFFFF);
        apply("R2 second stations only", 22'h0AAAA, 22'h3FFFFF);
        apply("R2 nothing", 22'h0, 22'h3FFFFF);
    endtask

    task automatic t_grades;
        // spectrometer 0 (arm0 Up), opposite is 5 (arm1 Down) on bits 10,11
        apply("R3 clean", 22'h00003, 22'h0);
        chk("R3 code value", 64'(spec_code[3:0]), 64'd1);
        apply("R4 first opposite halo", 22'h00003, 22'h00400);
        chk("R4 code value", 64'(spec_code[3:0]), 64'd2);
        apply("R4 second opposite halo", 22'h00003, 22'h00800);
        chk("R4 code value b", 64'(spec_code[3:0]), 64'd2);
        apply("R5 both opposite halo", 22'h00003, 22'h00C00);
        chk("R5 code value", 64'(spec_code[3:0]), 64'd3);
    endtask

    task automatic t_diag;
        for (int s = 0; s < 8; s++) begin
            int o;
            logic [21:0] it, hl;
            o = s ^ 5;
            it = 22'(3) << (2*s);
            hl = 22'h3FFFFF & ~(22'(3) << (2*o));
            apply("R6 non-opposite halo ignored", it, hl);
            chk("R6 pairing clean", 64'(spec_code), 64'(36'(1) << (4*s)));
            apply("R6 opposite halo", it, 22'(3) << (2*o));
            chk("R6 pairing halo", 64'(spec_code), 64'(36'(3) << (4*s)));
        end
    endtask

    task automatic t_dipole;
        apply("R7 dipole coincidence", 22'h30000, 22'h3FFFFF);
        chk("R7 dipole value", 64'(spec_code), 64'(36'h1_0000_0000));
        apply("R7 dipole single", 22'h10000, 22'h0);
        chk("R7 dipole zero", 64'(spec_code), 64'd0);
    endtask

    task automatic t_veto;
        apply("R8 veto set", 22'h3C00F0, 22'h3C0300);
        chk("R8 veto no effect", 64'(spec_code), 64'(model(22'h0000F0, 22'h000300)));
        apply("R8 only veto", 22'h3C0000, 22'h3C0000);
        chk("R8 only veto zero", 64'(spec_code), 64'd0);
    endtask

    task automatic t_upper;
        logic ok;
        apply("R9 all hits", 22'h3FFFFF, 22'h3FFFFF);
        ok = 1'b1;
        for (int s = 0; s < 9; s++)
            if (spec_code[4*s+2 +: 2] != 2'b00) ok = 1'b0;
        chk("R9 upper bits zero", 64'(ok), 64'd1);
    endtask

    task automatic t_back_to_back;
        logic [21:0] a_it, b_it, b_hl;
        a_it = 22'h00003;
        b_it = 22'h0C0C0;
        b_hl = 22'h00011;
        @(negedge clk);
        hit_intime = a_it; hit_halo = '0; bx_strobe = 1'b1;
        @(negedge clk);
        chk("R10 first of pair", 64'(spec_code), 64'(model(a_it, 22'h0)));
        chk("R10 valid pair a", 64'(codes_valid), 64'd1);
        hit_intime = b_it; hit_halo = b_hl;
        @(negedge clk);
        bx_strobe = 1'b0;
        chk("R10 second of pair", 64'(spec_code), 64'(model(b_it, b_hl)));
        chk("R10 valid pair b", 64'(codes_valid), 64'd1);
        @(negedge clk);
        chk("R10 valid after pair", 64'(codes_valid), 64'd0);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 60; i++) begin
            logic [21:0] it, hl;
            lfsr = nxt(lfsr);
            it = lfsr[21:0] | lfsr[31:10];
            lfsr = nxt(lfsr);
            hl = lfsr[21:0] & lfsr[31:10];
            apply("R1 mixed pattern", it, hl);
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_no_coinc();
        t_grades();
        t_diag();
        t_dipole();
        t_veto();
        t_upper();
        t_back_to_back();
        t_sweep();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 late reset codes", 64'(spec_code), 64'd0);
        chk("R11 late reset valid", 64'(codes_valid), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule